// File: doc/BRIEF.md
# Selectable Beep Tone Generator

This block drives a beeper pin with a rectangular tone. A 2-bit tone select picks one of four fixed pitches, and an enable input switches the tone on and off. The system clock is first divided down to a 10 kHz reference tick. The divide ratio is a module parameter, so the block can be placed in any clock domain whose frequency is a whole multiple of 10 kHz.

A phase counter advances once per reference tick and shapes each tone period. Three of the tones are square waves. The lowest tone is high for two thirds of its period, so every setting keeps its own high length and its own full period length. The tone select is sampled only when a tone starts and at each period boundary. A change made while a tone is sounding is therefore never seen in the middle of a period, and no shortened pulse can appear.

Top module: `beep_tone_gen`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `beep` is low. Reset clears the phase and prescaler counters, so the first tone after reset starts from the beginning of a period.
- R2: With `fsel` = 2'b00 the tone period is 24 ticks, of which the first 16 are high and the last 8 are low (about 417 Hz, 2/3 duty).
- R3: With `fsel` = 2'b01 the tone period is 10 ticks: 5 high, then 5 low (1 kHz).
- R4: With `fsel` = 2'b10 the tone period is 8 ticks: 4 high, then 4 low (1.25 kHz).
- R5: With `fsel` = 2'b11 the tone period is 4 ticks: 2 high, then 2 low (2.5 kHz).
- R6: One reference tick lasts exactly `CLK_DIV` clock cycles, so a phase of N ticks keeps `beep` steady for N*`CLK_DIV` cycles.
- R7: When `en` is sampled low, `beep` is low from the next cycle, and both counters return to zero. A change of `fsel` while `en` is low has no effect on `beep`.
- R8: A change of `fsel` while the tone runs takes effect only at the next period boundary. The current period finishes with its original high and low lengths.
- R9: On the first clock edge at which `en` is sampled high after being low, the select is captured and `beep` goes high on the next cycle, starting a full high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | System clock |
| rst  | input  | 1 | Synchronous reset, active high |
| en   | input  | 1 | Tone enable; low forces the output low |
| fsel | input  | 2 | Tone select (00: ~417 Hz, 01: 1 kHz, 10: 1.25 kHz, 11: 2.5 kHz) |
| beep | output | 1 | Tone output to the beeper |

## Verification
The hardest case to create is a change of the tone select in the middle of a period, especially during the long high phase of the asymmetric tone, where a wrong design would cut the pulse short. The stimulus starts that tone and waits a known number of cycles into its high phase before switching to the fastest tone. It then checks that the first pulse still has its full 16-tick length and that the faster pattern follows only after the 24-tick boundary. Disable and reset are also applied partway through a high phase, so that a restart from a non-zero phase would show up.

// File: rtl/beep_pkg.sv
package beep_pkg;

    // Reference tick counts shared by every tone setting
    localparam int TICK_HZ = 10000;
    localparam int POS_W   = 5;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic [1:0] {
        TONE_417   = 2'b00,
        TONE_1000  = 2'b01,
        TONE_1250  = 2'b10,
        TONE_2500  = 2'b11
    } tone_e;

    // Shape of one tone period, counted in reference ticks
    typedef struct packed {
        pos_t high_len;
        pos_t period;
    } shape_t;

    localparam pos_t LOW_TONE_HIGH   = pos_t'(16);
    localparam pos_t LOW_TONE_PERIOD = pos_t'(24);

    function automatic shape_t shape_of(tone_e t);
        shape_t s;
        case (t)
            TONE_417: begin
                s.high_len = LOW_TONE_HIGH;
                s.period   = LOW_TONE_PERIOD;
            end
            TONE_1000: begin
                s.high_len = pos_t'(5);
                s.period   = pos_t'(10);
            end
            TONE_1250: begin
                s.high_len = pos_t'(4);
                s.period   = pos_t'(8);
            end
            default: begin
                s.high_len = pos_t'(2);
                s.period   = pos_t'(4);
            end
        endcase
        return s;
    endfunction

    function automatic logic at_period_end(pos_t p, tone_e t);
        shape_t s;
        s = shape_of(t);
        return p == (s.period - pos_t'(1));
    endfunction

endpackage

// File: rtl/beep_prescaler.sv
module beep_prescaler #(
    parameter int CLK_DIV = 25000
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic tick
);
    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

    logic [CNT_W-1:0] pcnt;

    generate
        if (CLK_DIV <= 1) begin : g_bypass
            assign tick = go;
            always_ff @(posedge clk) pcnt <= '0;
        end else begin : g_count
            assign tick = go && (pcnt == LAST);
            always_ff @(posedge clk) begin
                if (rst || !go) begin
                    pcnt <= '0;
                end else if (pcnt == LAST) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + CNT_W'(1);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/beep_shaper.sv
module beep_shaper
    import beep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] fsel,
    input  logic       tick,
    output logic       run,
    output pos_t       pos,
    output tone_e      cur_tone,
    output logic       beep
);
    shape_t shape;

    always_comb begin
        shape = shape_of(cur_tone);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run      <= 1'b0;
            pos      <= '0;
            cur_tone <= TONE_417;
        end else if (!en) begin
            run <= 1'b0;
            pos <= '0;
        end else if (!run) begin
            run      <= 1'b1;
            pos      <= '0;
            cur_tone <= tone_e'(fsel);
        end else if (tick) begin
            if (at_period_end(pos, cur_tone)) begin
                pos      <= '0;
                cur_tone <= tone_e'(fsel);
            end else begin
                pos <= pos + pos_t'(1);
            end
        end
    end

    assign beep = run && (pos < shape.high_len);

endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
    import beep_pkg::*;
#(
    parameter int CLK_DIV = 25000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] fsel,
    output logic       beep
);
    logic  tick_w;
    logic  run_w;
    logic  go_w;
    pos_t  pos_w;
    tone_e tone_w;

    assign go_w = en && run_w;

    beep_prescaler #(.CLK_DIV(CLK_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .go   (go_w),
        .tick (tick_w)
    );

    beep_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .fsel     (fsel),
        .tick     (tick_w),
        .run      (run_w),
        .pos      (pos_w),
        .cur_tone (tone_w),
        .beep     (beep)
    );

endmodule

// File: rtl/beep_tone_gen_chk.sv
module beep_tone_gen_chk
    import beep_pkg::*;
#(
    parameter int CLK_DIV = 25000
) (
    input logic  clk,
    input logic  rst,
    input logic  en,
    input logic  beep,
    input logic  tick,
    input logic  go,
    input logic  run,
    input pos_t  pos,
    input tone_e tone
);
    int   gap;
    logic rst_q;
    shape_t sh;

    always_comb sh = shape_of(tone);

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || !go || tick) gap <= 0;
        else                    gap <= gap + 1;
    end

    // R1: output low on the cycle after reset
    always_ff @(posedge clk) begin
        if (rst_q) begin
            a_r1_reset_low: assert (!beep);
        end
    end

    // R7: disable silences the output
    a_r7_off_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !beep);

    // R9: a fresh enable begins with a high phase
    a_r9_start_high: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |=> beep);

    // R6: ticks are CLK_DIV cycles apart
    a_r6_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap == CLK_DIV - 1));

    // R8: the selected tone only changes at a boundary or a start
    a_r8_tone_hold: assert property (@(posedge clk) disable iff (rst)
        (run && !(tick && (pos == sh.period - pos_t'(1)))) |=> $stable(tone));

    // R2: phase stays inside the period of the running tone
    a_r2_pos_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (pos < sh.period));

endmodule

bind beep_tone_gen beep_tone_gen_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .beep (beep),
    .tick (tick_w),
    .go   (go_w),
    .run  (run_w),
    .pos  (pos_w),
    .tone (tone_w)
);

// File: tb/beep_tone_gen_test.sv
`timescale 1ns/1ps
module beep_tone_gen_test;
    localparam int DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] fsel = 2'b00;
    logic       beep;

    int compared = 0;
    int mismatched = 0;
    string cur_tag = "R1";
    bit done = 0;

    // Tone tables taken from R2..R5
    int HI[4]  = '{16, 5, 4, 2};
    int PER[4] = '{24, 10, 8, 4};

    // Behavioural reference state
    int m_on = 0, m_ph = 0, m_cy = 0, m_sel = 0;

    always #2 clk = ~clk;

    beep_tone_gen #(.CLK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .en(en), .fsel(fsel), .beep(beep)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_on = 0; m_ph = 0; m_cy = 0; m_sel = 0;
        end else if (!en) begin
            m_on = 0; m_ph = 0; m_cy = 0;
        end else if (m_on == 0) begin
            m_on = 1; m_ph = 0; m_cy = 0; m_sel = int'(fsel);
        end else if (m_cy == DIV - 1) begin
            m_cy = 0;
            if (m_ph == PER[m_sel] - 1) begin
                m_ph = 0; m_sel = int'(fsel);
            end else begin
                m_ph = m_ph + 1;
            end
        end else begin
            m_cy = m_cy + 1;
        end
    end

    task automatic check(string tag, logic ok, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the reference model
    always @(negedge clk) begin
        if (!done) begin
            logic e;
            e = (m_on != 0) && (m_ph < HI[m_sel]);
            check(cur_tag, beep === e, int'(beep), int'(e));
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_len(logic lvl, output int n);
        int guard = 0;
        while (beep !== lvl && guard < 1000) begin
            @(negedge clk); guard++;
        end
        n = 0;
        while (beep === lvl && n < 1000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic tone_case(logic [1:0] s, string tag);
        int h, l;
        cur_tag = tag;
        en = 1'b0; fsel = s;
        cycles(2);
        en = 1'b1;
        run_len(1'b1, h);
        check({tag, " high"}, h == HI[s] * DIV, h, HI[s] * DIV);
        run_len(1'b0, l);
        check({tag, " low"}, l == (PER[s] - HI[s]) * DIV, l, (PER[s] - HI[s]) * DIV);
        run_len(1'b1, h);
        check({tag, " 2nd high"}, h == HI[s] * DIV, h, HI[s] * DIV);
        en = 1'b0;
        cycles(2);
    endtask

    initial begin
        int h, l;
        cycles(3);
        check("R1 reset", beep === 1'b0, int'(beep), 0);
        rst = 1'b0;
        cycles(1);
        check("R1 after reset", beep === 1'b0, int'(beep), 0);

        tone_case(2'b00, "R2");
        tone_case(2'b01, "R3");
        tone_case(2'b10, "R4");
        tone_case(2'b11, "R5");

        // R6: a 2-tick phase of the fastest tone lasts 2*DIV cycles
        cur_tag = "R6";
        fsel = 2'b11; en = 1'b1;
        run_len(1'b1, h);
        check("R6 tick length", h == 2 * DIV, h, 2 * DIV);
        en = 1'b0; cycles(2);

        // R9: output high on the cycle after enable is sampled
        cur_tag = "R9";
        fsel = 2'b01; en = 1'b1;
        @(negedge clk);
        check("R9 start high", beep === 1'b1, int'(beep), 1);

        // R8: switch select in the middle of the long high phase
        cur_tag = "R8";
        en = 1'b0; cycles(2);
        fsel = 2'b00; en = 1'b1;
        cycles(5 * DIV);
        fsel = 2'b11;
        run_len(1'b0, l);
        check("R8 low kept", l == 8 * DIV, l, 8 * DIV);
        run_len(1'b1, h);
        check("R8 new tone", h == 2 * DIV, h, 2 * DIV);

        // R7: drop enable mid-high, select changes ignored while off
        cur_tag = "R7";
        fsel = 2'b00;
        cycles(PER[3] * DIV);
        en = 1'b0;
        @(negedge clk);
        check("R7 off next cycle", beep === 1'b0, int'(beep), 0);
        for (int i = 0; i < 4; i++) begin
            fsel = 2'(i);
            cycles(DIV + 1);
            check("R7 ignored while off", beep === 1'b0, int'(beep), 0);
        end
        fsel = 2'b10; en = 1'b1;
        run_len(1'b1, h);
        check("R7 restart full", h == 4 * DIV, h, 4 * DIV);

        // R1: reset during a running tone
        cur_tag = "R1";
        fsel = 2'b00;
        cycles(7);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", beep === 1'b0, int'(beep), 0);
        rst = 1'b0; en = 1'b0;
        cycles(2);
        en = 1'b1;
        run_len(1'b1, h);
        check("R1 restart after reset", h == 16 * DIV, h, 16 * DIV);
        cycles(10);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule